// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. A 16-bit up/down counter steps on the edges of channel A, of channel B, or of both. Each step goes up or down according to the level of the channel that did not move. Counting on one channel resolves two counts per encoder period, and counting on both resolves four. The count runs from zero to a programmable reload value. It wraps at either end, and each wrap produces a one-cycle pulse.

A 3-bit mode input picks the behaviour. With mode 0, or any value from 4 to 7, the encoder logic is off and the counter becomes a plain up-counter that advances every clock while an enable is high. The channel inputs must already be synchronous to the clock. Each input is compared with its value from the previous cycle, and a change on both channels in the same cycle is treated as a glitch and discarded.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `count` is 0, `dir_down` is 0 and `wrap_pulse` is 0.
- R2: In mode 0 the counter adds one on each clock edge at which `cnt_en` is 1 and holds when `cnt_en` is 0, whatever the channel inputs do.
- R3: In mode 1 (3'b001) only channel A edges are counted. After such an edge the step is down if `ch_a ^ ch_b` is 1 and up if it is 0. Channel B edges leave the count unchanged.
- R4: In mode 2 (3'b010) only channel B edges are counted. After such an edge the step is up if `ch_a ^ ch_b` is 1 and down if it is 0. Channel A edges leave the count unchanged.
- R5: In mode 3 (3'b011) edges of either channel are counted, using the rule of R3 for an A edge and the rule of R4 for a B edge. The level order 00,01,11,10 therefore adds four.
- R6: In modes 1 to 3, a cycle in which both channels change level (compared with the previous cycle) produces no step. The count and `dir_down` hold, and the new levels become the reference for later edges.
- R7: An up step taken when `count` is at or above `reload` sets `count` to 0 and raises `wrap_pulse` for exactly one cycle.
- R8: A down step taken when `count` is 0 sets `count` to `reload` and raises `wrap_pulse` for exactly one cycle.
- R9: `dir_down` shows the direction of the most recent step (1 = down, 0 = up) and holds while no step occurs. A free-running step counts as up.
- R10: Mode values 4 to 7 behave exactly as mode 0.
- R11: A level change presented before a clock edge is reflected in `count`, `dir_down` and `wrap_pulse` right after that same edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Counting mode: 0 free run, 1 channel A, 2 channel B, 3 both, 4-7 as 0 |
| cnt_en | input | 1 | Enable for the free-running modes |
| ch_a | input | 1 | Encoder channel A level, synchronous to clk |
| ch_b | input | 1 | Encoder channel B level, synchronous to clk |
| reload | input | 16 | Upper bound of the count range |
| count | output | 16 | Current position count |
| dir_down | output | 1 | Direction of the last step, 1 = down |
| wrap_pulse | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
The bench goes after the direction rule in each encoder mode. A design with the XOR sense reversed on one channel would make a single-channel mode count backwards, or make x4 mode cancel to zero over a period. It drives both channels changing in the same cycle. A design that did not discard that case would take a phantom step, and one that failed to update its reference levels would count a false edge afterwards. It crosses both wrap boundaries to catch an off-by-one at `reload` or a missing down-wrap pulse. It also runs modes 4 to 7 to catch a decoder that lets those codes fall into an encoder mode or stop the counter.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam logic [2:0] QM_FREE = 3'd0;
    localparam logic [2:0] QM_CH_A = 3'd1;
    localparam logic [2:0] QM_CH_B = 3'd2;
    localparam logic [2:0] QM_BOTH = 3'd3;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;

    typedef struct packed {
        logic step;
        logic down;
    } step_t;

    function automatic logic is_encoder_mode(logic [2:0] m);
        return (m == QM_CH_A) || (m == QM_CH_B) || (m == QM_BOTH);
    endfunction

endpackage

// File: rtl/qenc_edge_det.sv
module qenc_edge_det #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl_i,
    output logic [NCH-1:0] edge_o
);
    typedef struct packed {
        logic [NCH-1:0] lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign edge_o[g] = lvl_i[g] ^ st_q.lvl[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/qenc_step_dec.sv
module qenc_step_dec
    import qenc_pkg::*;
(
    input  logic        [2:0]        mode_i,
    input  logic                     cnt_en_i,
    input  logic        [NUM_CH-1:0] lvl_i,
    input  logic        [NUM_CH-1:0] edge_i,
    output step_t                    step_o
);
    logic parity;
    logic a_only;
    logic b_only;

    always_comb begin
        parity = lvl_i[CH_A] ^ lvl_i[CH_B];
        a_only = edge_i[CH_A] & ~edge_i[CH_B];
        b_only = edge_i[CH_B] & ~edge_i[CH_A];
        step_o = '0;
        unique case (mode_i)
            QM_CH_A: begin
                step_o.step = a_only;
                step_o.down = parity;
            end
            QM_CH_B: begin
                step_o.step = b_only;
                step_o.down = ~parity;
            end
            QM_BOTH: begin
                step_o.step = a_only | b_only;
                step_o.down = a_only ? parity : ~parity;
            end
            default: begin
                step_o.step = cnt_en_i;
                step_o.down = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         down_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         dir_down_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
        logic         wrap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (step_i) begin
            st_d.dir = down_i;
            if (down_i) begin
                if (st_q.cnt == ZERO) begin
                    st_d.cnt  = reload_i;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end else begin
                if (st_q.cnt >= reload_i) begin
                    st_d.cnt  = ZERO;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.cnt;
    assign dir_down_o = st_q.dir;
    assign wrap_o     = st_q.wrap;
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             cnt_en,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_pulse
);
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] edg;
    logic              a_edge;
    logic              b_edge;
    step_t             step;

    assign lvl[CH_A] = ch_a;
    assign lvl[CH_B] = ch_b;
    assign a_edge    = edg[CH_A];
    assign b_edge    = edg[CH_B];

    qenc_edge_det #(.NCH(NUM_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .edge_o (edg)
    );

    qenc_step_dec u_dec (
        .mode_i   (mode),
        .cnt_en_i (cnt_en),
        .lvl_i    (lvl),
        .edge_i   (edg),
        .step_o   (step)
    );

    qenc_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step.step),
        .down_i     (step.down),
        .reload_i   (reload),
        .count_o    (count),
        .dir_down_o (dir_down),
        .wrap_o     (wrap_pulse)
    );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             cnt_en,
    input logic             a_edge,
    input logic             b_edge,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             wrap_pulse
);
    logic enc_mode;
    assign enc_mode = qenc_pkg::is_encoder_mode(mode);

    p_stable_en_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_mode && !cnt_en) |=> ($stable(count) && !wrap_pulse));

    p_b_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && !a_edge) |=> ($stable(count) && $stable(dir_down)));

    p_a_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !b_edge) |=> ($stable(count) && $stable(dir_down)));

    p_both_edges_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && a_edge && b_edge) |=> ($stable(count) && !wrap_pulse));

    p_wrap_up_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pulse && !dir_down) |-> (count == '0));

    p_wrap_down_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_pulse) && dir_down |-> (count == $past(reload)));
endmodule

bind quad_pos_counter qenc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .cnt_en     (cnt_en),
    .a_edge     (a_edge),
    .b_edge     (b_edge),
    .reload     (reload),
    .count      (count),
    .dir_down   (dir_down),
    .wrap_pulse (wrap_pulse)
);

// File: tb/quad_pos_counter_tb.sv
`timescale 1ns/1ps
module quad_pos_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        cnt_en = 1'b0;
    logic        ch_a = 1'b0;
    logic        ch_b = 1'b0;
    logic [15:0] reload = 16'd100;
    logic [15:0] count;
    logic        dir_down;
    logic        wrap_pulse;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    quad_pos_counter u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_en(cnt_en),
        .ch_a(ch_a), .ch_b(ch_b), .reload(reload),
        .count(count), .dir_down(dir_down), .wrap_pulse(wrap_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int c, input int d, input int w);
        chk({req, " count"}, int'(count), c);
        chk({req, " dir_down"}, int'(dir_down), d);
        chk({req, " wrap_pulse"}, int'(wrap_pulse), w);
    endtask

    task automatic do_reset(input logic [2:0] m, input logic [15:0] rl);
        @(negedge clk);
        rst_n = 1'b0; ch_a = 1'b0; ch_b = 1'b0; cnt_en = 1'b0;
        mode = m; reload = rl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick(input logic a, input logic b);
        ch_a = a; ch_b = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_r1();
        do_reset(3'd3, 16'd100);
        chk_out("R1", 0, 0, 0);
        tick(1'b0, 1'b0);
        chk_out("R1", 0, 0, 0);
    endtask

    task automatic t_free_r2();
        do_reset(3'd0, 16'd100);
        cnt_en = 1'b1;
        tick(1'b1, 1'b0);
        chk_out("R2 R11", 1, 0, 0);
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        chk_out("R2", 3, 0, 0);
        cnt_en = 1'b0;
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b0);
        chk_out("R2 hold", 3, 0, 0);
    endtask

    task automatic t_mode1_r3();
        do_reset(3'd1, 16'd100);
        tick(1'b0, 1'b1); chk("R3 B edge ignored", int'(count), 0);
        tick(1'b1, 1'b1); chk_out("R3 up", 1, 0, 0);
        tick(1'b1, 1'b0); chk("R3 B edge ignored", int'(count), 1);
        tick(1'b0, 1'b0); chk_out("R3 up", 2, 0, 0);
        tick(1'b1, 1'b0); chk_out("R3 down", 1, 1, 0);
        tick(1'b1, 1'b1); chk_out("R3 R9 hold", 1, 1, 0);
        tick(1'b0, 1'b1); chk_out("R3 down", 0, 1, 0);
    endtask

    task automatic t_mode2_r4();
        do_reset(3'd2, 16'd100);
        tick(1'b0, 1'b1); chk_out("R4 up", 1, 0, 0);
        tick(1'b1, 1'b1); chk("R4 A edge ignored", int'(count), 1);
        tick(1'b1, 1'b0); chk_out("R4 up", 2, 0, 0);
        tick(1'b0, 1'b0); chk("R4 A edge ignored", int'(count), 2);
        tick(1'b1, 1'b0); chk("R4 A edge ignored", int'(count), 2);
        tick(1'b1, 1'b1); chk_out("R4 down", 1, 1, 0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0); chk_out("R4 down", 0, 1, 0);
    endtask

    task automatic t_mode3_r5();
        do_reset(3'd3, 16'd100);
        for (int i = 0; i < 2; i++) begin
            tick(1'b0, 1'b1); tick(1'b1, 1'b1);
            tick(1'b1, 1'b0); tick(1'b0, 1'b0);
        end
        chk_out("R5 x4 up", 8, 0, 0);
        tick(1'b1, 1'b0); chk_out("R5 R9 down", 7, 1, 0);
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b1); chk_out("R5 down", 5, 1, 0);
    endtask

    task automatic t_both_r6();
        do_reset(3'd3, 16'd100);
        tick(1'b1, 1'b1); chk_out("R6 both dropped", 0, 0, 0);
        tick(1'b1, 1'b0); chk_out("R6 reference updated", 1, 0, 0);
        tick(1'b0, 1'b1); chk_out("R6 both dropped", 1, 0, 0);
    endtask

    task automatic t_wrap_up_r7();
        do_reset(3'd0, 16'd3);
        cnt_en = 1'b1;
        tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        chk_out("R7 at reload", 3, 0, 0);
        tick(1'b0, 1'b0); chk_out("R7 wrap", 0, 0, 1);
        tick(1'b0, 1'b0); chk_out("R7 pulse one cycle", 1, 0, 0);
    endtask

    task automatic t_wrap_down_r8();
        do_reset(3'd3, 16'd5);
        tick(1'b1, 1'b0); chk_out("R8 wrap", 5, 1, 1);
        tick(1'b1, 1'b1); chk_out("R8 pulse one cycle", 4, 1, 0);
    endtask

    task automatic t_high_modes_r10();
        for (int m = 4; m < 8; m++) begin
            do_reset(3'(m), 16'd100);
            cnt_en = 1'b1;
            tick(1'b1, 1'b0); tick(1'b1, 1'b1); tick(1'b0, 1'b1);
            chk_out($sformatf("R10 mode %0d", m), 3, 0, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_free_r2();
        t_mode1_r3();
        t_mode2_r4();
        t_mode3_r5();
        t_both_r6();
        t_wrap_up_r7();
        t_wrap_down_r8();
        t_high_modes_r10();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule